// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block holds the control and status word of a real-time clock. It sits between a fast bus-clock register port and a slow RTC-clock core. Software uses it to turn the clock on, to choose which alarm and ready events raise an interrupt, and to set up the square-wave output. The block also keeps three sticky event flags: count-ready, time-of-day alarm and sub-second alarm. From these it drives a combined interrupt line and a wake line.

Three settings count as critical: the clock run enable and the two alarm interrupt enables. Software writes them into a staging copy in the bus domain. A toggle request/acknowledge handshake with multi-flop synchronizers carries that copy into the RTC domain. While the copy is crossing, a read-only busy bit stays high. A new value takes effect only when busy falls. It then shows on the RTC-domain outputs and in the interrupt gating. The run enable has an extra guard: it accepts a write only while a separate write-protect-release bit is already 1.

The core delivers its events as single-cycle pulses that are already synchronous to the bus clock. These are count-update start, count-update done, time-of-day alarm hit and sub-second alarm hit. The register reads back combinationally on `rdata_o`.

Top module: `rtcc_ctrl`

## Requirements
- R1: The run enable (bit 1) takes a written value only if the stored write-unlock bit (bit 0) is already 1 and busy is 0. Any other write leaves bit 1 unchanged and does not raise busy.
- R2: An accepted write that changes the run enable, the time-of-day alarm enable (bit 2) or the sub-second alarm enable (bit 3) raises busy (bit 5) on the next cycle and reads back the new value at once. The new value reaches `rtc_en_o`/`rtc_tod_ie_o`/`rtc_sub_ie_o` and the interrupt gating only when busy falls.
- R3: While busy is 1, writes to bits 1 to 3 are ignored. Busy returns to 0 by itself once the RTC domain has taken the staged copy.
- R4: The ready flag (bit 6) has this priority order: it sets on `upd_done_i`, it clears on `upd_start_i`, and a software write of 0 clears it. Writing 1 has no effect.
- R5: `irq_o` is (ready AND ready-interrupt-enable bit 4) OR (time-of-day flag AND effective time-of-day enable) OR (sub-second flag AND effective sub-second enable).
- R6: The time-of-day flag (bit 7) and the sub-second flag (bit 8) latch their hit pulse. A write of 0 clears a flag and a write of 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R7: `wake_o` is 1 whenever either alarm flag is 1, regardless of the interrupt enables.
- R8: The square-wave select field (bits 11:10) encodes 0 = 1 Hz, 1 = 512 Hz, 2 = 4 kHz and 3 = input clock divided by 8. `sqw_sel_o` presents the field only while the square-wave enable (bit 9, also on `sqw_en_o`) is 1, and presents 0 otherwise.
- R9: After reset every register bit, `irq_o`, `wake_o`, `sqw_en_o`, `sqw_sel_o` and the RTC-domain outputs are 0.
- R10: Bits 0, 4 and 9 to 11 take a write at any time, regardless of write unlock and busy. Writes to busy (bit 5) and to unused bits have no effect, and those bits read back as 0 unless busy is set by hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain asynchronous reset, active low |
| rtc_clk_i | input | 1 | RTC core clock |
| rtc_rst_ni | input | 1 | RTC-domain asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Register read data |
| upd_start_i | input | 1 | Pulse: count update about to happen |
| upd_done_i | input | 1 | Pulse: count update finished |
| tod_hit_i | input | 1 | Pulse: time-of-day alarm match |
| sub_hit_i | input | 1 | Pulse: sub-second alarm match |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Wake request from either alarm flag |
| sqw_en_o | output | 1 | Square-wave enable |
| sqw_sel_o | output | 2 | Square-wave frequency code |
| rtc_en_o | output | 1 | Effective run enable, RTC domain |
| rtc_tod_ie_o | output | 1 | Effective time-of-day alarm enable, RTC domain |
| rtc_sub_ie_o | output | 1 | Effective sub-second alarm enable, RTC domain |

## Verification
The bench writes the run enable while the register is still locked, and again while busy is high. A design that ignored the unlock bit or the busy guard would flip the enable or restart the transfer mid-flight. It reads the interrupt just after an enable change and again after busy falls, which catches a design that applies staged values early. Clearing writes collide with hit and update pulses in the same cycle, so a design with the wrong priority loses an event. The random phase mixes writes that leave the locked bits unchanged with random event pulses. It checks the flag, interrupt, wake and square-wave behaviour against a bench model.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

   // Bit positions inside the control word
   localparam int unsigned F_UNLK   = 0;
   localparam int unsigned F_RUN    = 1;
   localparam int unsigned F_TODIE  = 2;
   localparam int unsigned F_SUBIE  = 3;
   localparam int unsigned F_RDYIE  = 4;
   localparam int unsigned F_BUSY   = 5;
   localparam int unsigned F_RDY    = 6;
   localparam int unsigned F_TOD    = 7;
   localparam int unsigned F_SUB    = 8;
   localparam int unsigned F_SQE    = 9;
   localparam int unsigned F_SEL    = 10;
   localparam int unsigned SEL_W    = 2;
   localparam int unsigned FIELD_TOP = F_SEL + SEL_W;

   // Settings that must cross into the RTC domain
   typedef struct packed {
      logic sub_ie;
      logic tod_ie;
      logic run;
   } crit_t;

   localparam int unsigned CRIT_W = $bits(crit_t);

   typedef enum logic [SEL_W-1:0] {
      SQW_1HZ   = 2'd0,
      SQW_512HZ = 2'd1,
      SQW_4KHZ  = 2'd2,
      SQW_DIV8  = 2'd3
   } sqw_sel_e;

endpackage

// File: rtl/rtcc_sync.sv
module rtcc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rtcc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[LAST];

endmodule

// File: rtl/rtcc_flag.sv
module rtcc_flag #(
   parameter bit HW_CLR_EN = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic hw_clr_i,
   input  logic sw_wr_i,
   input  logic sw_val_i,
   output logic flag_o
);

   logic flag_q;
   logic clr_hw;

   generate
      if (HW_CLR_EN) begin : g_hwclr
         assign clr_hw = hw_clr_i;
      end else begin : g_nohwclr
         logic unused_hw_clr;
         assign unused_hw_clr = hw_clr_i;
         assign clr_hw = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_hw) begin
         flag_q <= 1'b0;
      end else if (sw_wr_i && !sw_val_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_o); // R6

   AST_W1_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !flag_o) |=> !flag_o); // R4

endmodule

// File: rtl/rtcc_xfer.sv
module rtcc_xfer #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   output logic         busy_o,
   output logic [W-1:0] staged_o,
   output logic [W-1:0] applied_o,
   input  logic         rtc_clk_i,
   input  logic         rtc_rst_ni,
   output logic [W-1:0] rtc_data_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("rtcc_xfer: W must be at least 1");
      end
   endgenerate

   // ---------------- bus side ----------------
   logic         req_q;
   logic         ack_s;
   logic         ack_d;
   logic [W-1:0] stg_q;
   logic [W-1:0] app_q;
   logic         take;

   assign busy_o = req_q ^ ack_d;
   assign take   = load_i && !busy_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
         stg_q <= '0;
      end else if (take) begin
         req_q <= ~req_q;
         stg_q <= data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ack_d <= 1'b0;
         app_q <= '0;
      end else begin
         ack_d <= ack_s;
         if (ack_s != ack_d) begin
            app_q <= stg_q;
         end
      end
   end

   assign staged_o  = stg_q;
   assign applied_o = app_q;

   // ---------------- RTC side ----------------
   logic         req_s;
   logic         seen_q;
   logic [W-1:0] rtc_q;

   rtcc_sync #(.STAGES(STAGES)) i_req_sync (
      .clk_i  (rtc_clk_i),
      .rst_ni (rtc_rst_ni),
      .d_i    (req_q),
      .q_o    (req_s)
   );

   always_ff @(posedge rtc_clk_i or negedge rtc_rst_ni) begin
      if (!rtc_rst_ni) begin
         seen_q <= 1'b0;
         rtc_q  <= '0;
      end else if (req_s != seen_q) begin
         seen_q <= req_s;
         rtc_q  <= stg_q;
      end
   end

   assign rtc_data_o = rtc_q;

   rtcc_sync #(.STAGES(STAGES)) i_ack_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (seen_q),
      .q_o    (ack_s)
   );

   AST_STG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> $stable(stg_q)); // R3

   AST_APPLY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(app_q) |-> $fell(busy_o)); // R2

   AST_LOAD_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take |=> busy_o); // R2

endmodule

// File: rtl/rtcc_ctrl.sv
module rtcc_ctrl
   import rtcc_pkg::*;
#(
   parameter int unsigned REG_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rtc_clk_i,
   input  logic             rtc_rst_ni,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] rdata_o,
   input  logic             upd_start_i,
   input  logic             upd_done_i,
   input  logic             tod_hit_i,
   input  logic             sub_hit_i,
   output logic             irq_o,
   output logic             wake_o,
   output logic             sqw_en_o,
   output logic [1:0]       sqw_sel_o,
   output logic             rtc_en_o,
   output logic             rtc_tod_ie_o,
   output logic             rtc_sub_ie_o
);

   generate
      if (REG_W < FIELD_TOP) begin : g_bad_w
         $error("rtcc_ctrl: REG_W too small for the field layout");
      end
      if (SEL_W != 2) begin : g_bad_sel
         $error("rtcc_ctrl: select field must be two bits wide");
      end
   endgenerate

   // ---------------- directly written fields ----------------
   logic             unlk_q;
   logic             rdyie_q;
   logic             sqe_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         unlk_q  <= 1'b0;
         rdyie_q <= 1'b0;
         sqe_q   <= 1'b0;
         sel_q   <= SQW_1HZ;
      end else if (wr_i) begin
         unlk_q  <= wdata_i[F_UNLK];
         rdyie_q <= wdata_i[F_RDYIE];
         sqe_q   <= wdata_i[F_SQE];
         sel_q   <= wdata_i[F_SEL +: SEL_W];
      end
   end

   // ---------------- critical settings ----------------
   crit_t stg;
   crit_t app;
   crit_t rtc_eff;
   crit_t next_crit;
   logic  busy;
   logic  load;

   always_comb begin
      next_crit.run    = unlk_q ? wdata_i[F_RUN] : stg.run;
      next_crit.tod_ie = wdata_i[F_TODIE];
      next_crit.sub_ie = wdata_i[F_SUBIE];
   end

   assign load = wr_i && !busy && (next_crit != stg);

   rtcc_xfer #(
      .W      (CRIT_W),
      .STAGES (SYNC_STAGES)
   ) i_xfer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .data_i     (next_crit),
      .busy_o     (busy),
      .staged_o   (stg),
      .applied_o  (app),
      .rtc_clk_i  (rtc_clk_i),
      .rtc_rst_ni (rtc_rst_ni),
      .rtc_data_o (rtc_eff)
   );

   assign rtc_en_o     = rtc_eff.run;
   assign rtc_tod_ie_o = rtc_eff.tod_ie;
   assign rtc_sub_ie_o = rtc_eff.sub_ie;

   // ---------------- event flags ----------------
   logic rdy;
   logic tod;
   logic sub;

   rtcc_flag #(.HW_CLR_EN(1'b1)) i_rdy_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (upd_done_i),
      .hw_clr_i (upd_start_i),
      .sw_wr_i  (wr_i),
      .sw_val_i (wdata_i[F_RDY]),
      .flag_o   (rdy)
   );

   rtcc_flag #(.HW_CLR_EN(1'b0)) i_tod_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (tod_hit_i),
      .hw_clr_i (1'b0),
      .sw_wr_i  (wr_i),
      .sw_val_i (wdata_i[F_TOD]),
      .flag_o   (tod)
   );

   rtcc_flag #(.HW_CLR_EN(1'b0)) i_sub_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (sub_hit_i),
      .hw_clr_i (1'b0),
      .sw_wr_i  (wr_i),
      .sw_val_i (wdata_i[F_SUB]),
      .flag_o   (sub)
   );

   // ---------------- outputs ----------------
   assign irq_o     = (rdy & rdyie_q) | (tod & app.tod_ie) | (sub & app.sub_ie);
   assign wake_o    = tod | sub;
   assign sqw_en_o  = sqe_q;
   assign sqw_sel_o = sqe_q ? sel_q : SQW_1HZ;

   always_comb begin
      rdata_o                  = '0;
      rdata_o[F_UNLK]          = unlk_q;
      rdata_o[F_RUN]           = stg.run;
      rdata_o[F_TODIE]         = stg.tod_ie;
      rdata_o[F_SUBIE]         = stg.sub_ie;
      rdata_o[F_RDYIE]         = rdyie_q;
      rdata_o[F_BUSY]          = busy;
      rdata_o[F_RDY]           = rdy;
      rdata_o[F_TOD]           = tod;
      rdata_o[F_SUB]           = sub;
      rdata_o[F_SQE]           = sqe_q;
      rdata_o[F_SEL +: SEL_W]  = sel_q;
   end

   logic unused_bits;
   assign unused_bits = ^{wdata_i, app.run};

   AST_RUN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && (!unlk_q || busy)) |=> $stable(stg.run)); // R1

   AST_RDY_PRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_start_i && !upd_done_i) |=> !rdy); // R4

   AST_RDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_done_i |=> rdy); // R4

   AST_SQW_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[F_SQE]) |=> (sqw_sel_o == SQW_1HZ)); // R8

endmodule

// File: tb/test_rtcc_ctrl.sv
module test_rtcc_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int RTC_PERIOD = 34;
   localparam int REG_W      = 16;

   localparam logic [REG_W-1:0] B_UNLK = 16'h0001;
   localparam logic [REG_W-1:0] B_RUN  = 16'h0002;
   localparam logic [REG_W-1:0] B_TIE  = 16'h0004;
   localparam logic [REG_W-1:0] B_SIE  = 16'h0008;
   localparam logic [REG_W-1:0] B_RIE  = 16'h0010;
   localparam logic [REG_W-1:0] B_BUSY = 16'h0020;
   localparam logic [REG_W-1:0] B_RDY  = 16'h0040;
   localparam logic [REG_W-1:0] B_TOD  = 16'h0080;
   localparam logic [REG_W-1:0] B_SUB  = 16'h0100;
   localparam logic [REG_W-1:0] B_SQE  = 16'h0200;
   localparam logic [REG_W-1:0] KEEP   = B_RDY | B_TOD | B_SUB;

   logic clk = 1'b0;
   logic rtc_clk = 1'b0;
   logic rst_n = 1'b0;
   logic rtc_rst_n = 1'b0;
   logic wr = 1'b0;
   logic [REG_W-1:0] wdata = '0;
   logic [REG_W-1:0] rdata;
   logic us = 1'b0, ud = 1'b0, th = 1'b0, sh = 1'b0;
   logic irq, wake, sqe_o, ren, rtie, rsie;
   logic [1:0] sel_o;

   int checks = 0;
   int errors = 0;

   // model state for the random phase
   logic m_unlk, m_rie, m_rdy, m_tod, m_sub, m_sqe;
   logic [1:0] m_sel;

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(RTC_PERIOD/2) rtc_clk = ~rtc_clk;

   rtcc_ctrl #(.REG_W(REG_W), .SYNC_STAGES(2)) i_rtcc_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .rtc_clk_i(rtc_clk), .rtc_rst_ni(rtc_rst_n),
      .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
      .upd_start_i(us), .upd_done_i(ud), .tod_hit_i(th), .sub_hit_i(sh),
      .irq_o(irq), .wake_o(wake), .sqw_en_o(sqe_o), .sqw_sel_o(sel_o),
      .rtc_en_o(ren), .rtc_tod_ie_o(rtie), .rtc_sub_ie_o(rsie)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bus cycle: inputs driven at a falling edge, results visible at the next falling edge
   task automatic step(input logic w, input logic [REG_W-1:0] d,
                       input logic a, input logic b, input logic c, input logic e);
      wr = w; wdata = d; us = a; ud = b; th = c; sh = e;
      @(negedge clk);
      wr = 1'b0; us = 1'b0; ud = 1'b0; th = 1'b0; sh = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (rdata[5] && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(!rdata[5], req, {31'd0, rdata[5]}, 0);
   endtask

   function automatic logic [REG_W-1:0] model_word();
      logic [REG_W-1:0] v = '0;
      v[0] = m_unlk; v[1] = 1'b1; v[2] = 1'b1; v[3] = 1'b0;
      v[4] = m_rie; v[6] = m_rdy; v[7] = m_tod; v[8] = m_sub;
      v[9] = m_sqe; v[11:10] = m_sel;
      return v;
   endfunction

   function automatic logic model_irq();
      return (m_rdy & m_rie) | m_tod;  // time-of-day enable is 1, sub-second enable 0
   endfunction

   initial begin
      #(CLK_PERIOD*200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; rtc_rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk(rdata == '0, "R9 rdata", rdata, 0);
      chk({irq, wake, sqe_o, sel_o, ren, rtie, rsie} == '0, "R9 outputs",
          {irq, wake, sqe_o, sel_o, ren, rtie, rsie}, 0);

      // R1 run enable while locked
      step(1, B_RUN | KEEP, 0, 0, 0, 0);
      chk(rdata[1] == 1'b0, "R1 locked write", rdata[1], 0);
      chk(rdata[5] == 1'b0, "R1 no busy", rdata[5], 0);

      // unlock, then enable: R2 busy and delayed effect
      step(1, B_UNLK | KEEP, 0, 0, 0, 0);
      step(1, B_UNLK | B_RUN | KEEP, 0, 0, 0, 0);
      chk(rdata[5] == 1'b1, "R2 busy rises", rdata[5], 1);
      chk(rdata[1] == 1'b1, "R2 readback new", rdata[1], 1);
      chk(ren == 1'b0, "R2 not yet effective", ren, 0);
      // R3 write during busy ignored
      step(1, B_UNLK | KEEP, 0, 0, 0, 0);
      chk(rdata[1] == 1'b1, "R3 write while busy", rdata[1], 1);
      wait_idle("R3 busy self clears");
      chk(ren == 1'b1, "R2 rtc enable applied", ren, 1);

      // R7 wake without enable; R2 alarm enable delayed
      step(0, '0, 0, 0, 1, 0);
      chk(wake == 1'b1, "R7 wake", wake, 1);
      chk(irq == 1'b0, "R5 irq gated off", irq, 0);
      step(1, B_UNLK | B_RUN | B_TIE | KEEP, 0, 0, 0, 0);
      chk(irq == 1'b0, "R2 enable not yet applied", irq, 0);
      wait_idle("R3 busy clears after enable");
      chk(irq == 1'b1, "R5 irq tod", irq, 1);
      chk(rtie == 1'b1, "R2 rtc tod enable", rtie, 1);

      // R6 set wins over clearing write, then clear
      step(1, B_UNLK | B_RUN | B_TIE | B_RDY | B_SUB, 0, 0, 1, 0);
      chk(rdata[7] == 1'b1, "R6 set wins", rdata[7], 1);
      step(1, B_UNLK | B_RUN | B_TIE | B_RDY | B_SUB, 0, 0, 0, 0);
      chk(rdata[7] == 1'b0, "R6 cleared by write 0", rdata[7], 0);
      chk(wake == 1'b0, "R7 wake low", wake, 0);
      step(0, '0, 0, 0, 0, 1);
      chk(rdata[8] == 1'b1 && wake && !irq, "R6 sub latch no irq", {wake, irq}, 2);

      // R4 ready flag
      step(0, '0, 0, 1, 0, 0);
      chk(rdata[6] == 1'b1, "R4 set on done", rdata[6], 1);
      chk(irq == 1'b0, "R5 ready ie off", irq, 0);
      step(0, '0, 1, 0, 0, 0);
      chk(rdata[6] == 1'b0, "R4 clear before update", rdata[6], 0);
      step(0, '0, 0, 1, 0, 0);
      step(1, B_UNLK | B_RUN | B_TIE | B_RIE | KEEP, 0, 0, 0, 0);
      chk(rdata[6] == 1'b1, "R4 write 1 no effect", rdata[6], 1);
      chk(irq == 1'b1, "R5 ready irq", irq, 1);
      step(1, B_UNLK | B_RUN | B_TIE | B_RIE | B_TOD | B_SUB, 0, 1, 0, 0);
      chk(rdata[6] == 1'b1, "R4 done beats clear", rdata[6], 1);
      step(1, B_UNLK | B_RUN | B_TIE | B_RIE | B_TOD | B_SUB, 0, 0, 0, 0);
      chk(rdata[6] == 1'b0, "R4 write 0 clears", rdata[6], 0);

      // R8 square wave
      step(1, B_UNLK | B_RUN | B_TIE | KEEP | 16'h0800, 0, 0, 0, 0);
      chk(sel_o == 2'd0 && rdata[11:10] == 2'd2, "R8 gated select", {rdata[11:10], sel_o}, 8);
      step(1, B_UNLK | B_RUN | B_TIE | KEEP | B_SQE | 16'h0C00, 0, 0, 0, 0);
      chk(sel_o == 2'd3 && sqe_o, "R8 div8 select", sel_o, 3);

      // R10 fields while locked; busy and unused bits ignored
      step(1, B_RUN | B_TIE | KEEP | B_BUSY | 16'hF000 | B_SQE | 16'h0400, 0, 0, 0, 0);
      chk(rdata == (B_RUN | B_TIE | B_SUB | B_SQE | 16'h0400), "R10 free fields",
          rdata, B_RUN | B_TIE | B_SUB | B_SQE | 16'h0400);
      chk(sel_o == 2'd1, "R8 512 Hz code", sel_o, 1);
      // R1 disable while locked ignored
      step(1, B_TIE | KEEP, 0, 0, 0, 0);
      chk(rdata[1] == 1'b1 && rdata[5] == 1'b0, "R1 locked clear", rdata[5:0], 6'h06);

      // known state for random phase
      step(1, B_RUN | B_TIE, 0, 0, 0, 0);
      m_unlk = 0; m_rie = 0; m_rdy = 0; m_tod = 0; m_sub = 0; m_sqe = 0; m_sel = 0;
      chk(rdata == model_word(), "R10 sync state", rdata, model_word());

      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 400; i++) begin
         logic w, a, b, c, e;
         logic [REG_W-1:0] d;
         w = $urandom_range(0, 1);
         d = REG_W'($urandom);
         d[1] = 1'b1; d[2] = 1'b1; d[3] = 1'b0;
         a = ($urandom_range(0, 7) == 0);
         b = ($urandom_range(0, 7) == 0);
         c = ($urandom_range(0, 7) == 0);
         e = ($urandom_range(0, 7) == 0);
         step(w, d, a, b, c, e);
         if (w) begin
            m_unlk = d[0]; m_rie = d[4]; m_sqe = d[9]; m_sel = d[11:10];
         end
         m_rdy = b ? 1'b1 : a ? 1'b0 : (w && !d[6]) ? 1'b0 : m_rdy;
         m_tod = c ? 1'b1 : (w && !d[7]) ? 1'b0 : m_tod;
         m_sub = e ? 1'b1 : (w && !d[8]) ? 1'b0 : m_sub;
         chk(rdata == model_word(), "R4 R6 R10 random word", rdata, model_word());
         chk(irq == model_irq() && wake == (m_tod | m_sub), "R5 R7 random irq/wake",
             {irq, wake}, {model_irq(), m_tod | m_sub});
         chk(sel_o == (m_sqe ? m_sel : 2'd0), "R8 random select", sel_o, m_sqe ? m_sel : 2'd0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule